// File: doc/BRIEF.md
# ADC Sequence Status Flag Logic

This block holds the status flags of a multi-channel analog-to-digital conversion sequencer. For each channel it keeps a flag that records a finished conversion. It also keeps a flag for a finished sequence, a flag that records a trigger edge arriving while a conversion is already running, and a flag that records a lost result (result-queue overrun). The converter and its timing engine sit outside the block. They send it one-cycle event pulses. A register bus writes control, start and status registers and reads result registers.

Several clear paths act on the same flags, and the block arbitrates them per bit with a fixed priority. The clear paths are a write-one-to-clear status write, an abort caused by a control write, a start write, an external-trigger start and an optional clear on result read. A clear of one channel never masks a set of another channel. A start write also opens a short blanking window. During this window, completions from the conversion that was in flight are discarded, so a new sequence always begins with clean flags.

Top module: `adc_seq_flags`

## Requirements
- R1: After synchronous reset, every flag output (channel flags, sequence flag, trigger-overrun, result-overrun, interrupt flag) is 0.
- R2: A pulse on bit i of `chan_done` sets `ch_flags[i]` one clock later. The flag then holds until a clear path removes it.
- R3: A bus write to address 3 (start) clears all channel flags, the sequence flag and the interrupt flag one clock later. This clear wins over any set that arrives in the same cycle.
- R4: `chan_done` and `seq_done` pulses are discarded in the start-write cycle and in the GUARD_CYC (default 2) cycles that follow it. They are accepted again from the cycle after that.
- R5: When `fast_clr_en` is 1, a result read (`res_rd`) clears `ch_flags[res_idx]` one clock later. When `fast_clr_en` is 0, a read has no effect on any flag.
- R6: A read-clear of channel x never blocks a set of channel y in the same cycle, and it leaves all other flags untouched. If the same channel is both set and read-cleared in one cycle, the set wins.
- R7: A bus write to address 4 is write-one-to-clear. Data bit 0 clears the sequence flag, bit 1 clears the trigger-overrun flag and bit 2 clears the result-overrun flag. A 0 bit has no effect. A set event in the same cycle wins over this clear.
- R8: A bus write to address 0, 1 or 2 (control) aborts the sequence and clears the trigger-overrun flag. This clear wins over a same-cycle set. Channel, sequence and result-overrun flags are unaffected.
- R9: The trigger-overrun flag sets only on an active `trig_in` edge seen while `conv_busy` is 1. The edge is rising when `trig_pol` is 1 and falling when `trig_pol` is 0. The inactive edge, or an edge while idle, has no effect.
- R10: A `fifo_ovf` pulse sets the result-overrun flag. A start write or an `ext_start` pulse clears it, and this clear wins over a same-cycle set.
- R11: `seq_irq` equals the next-cycle sequence flag gated by `seq_irq_en`. It is 0 whenever the enable is 0.
- R12: `seq_start` is 1 in exactly the cycles with a bus write to address 3. `seq_abort` is 1 in exactly the cycles with a bus write to addresses 0 to 2. Both outputs are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0-2 control, 3 start, 4 status clear |
| bus_wdata | input | 3 | Status clear bits (bit0 sequence, bit1 trigger overrun, bit2 result overrun) |
| res_rd | input | 1 | Result register read strobe |
| res_idx | input | IDX_W (3) | Index of the result register being read |
| fast_clr_en | input | 1 | Enables clear-on-read of channel flags |
| seq_irq_en | input | 1 | Sequence interrupt enable |
| trig_pol | input | 1 | Active trigger edge: 1 rising, 0 falling |
| trig_in | input | 1 | Synchronous external trigger level |
| conv_busy | input | 1 | A conversion is in progress |
| chan_done | input | N_CH (8) | Per-channel conversion-complete pulses |
| seq_done | input | 1 | Sequence-complete pulse |
| ext_start | input | 1 | Sequence started by external trigger |
| fifo_ovf | input | 1 | Result overwritten before read |
| ch_flags | output | N_CH (8) | Per-channel complete flags |
| seq_flag | output | 1 | Sequence complete flag |
| trig_ovr | output | 1 | Trigger overrun flag |
| fifo_ovr | output | 1 | Result overrun flag |
| seq_irq | output | 1 | Sequence interrupt flag |
| seq_start | output | 1 | Decoded start-write pulse |
| seq_abort | output | 1 | Decoded control-write abort pulse |

## Verification
Every flag is one register deep, so a stimulus applied in one cycle shows on the flag outputs one clock later. The bench drives inputs at the falling edge and reads the flags a quarter period after the next rising edge. The decoded `seq_start` and `seq_abort` pulses are combinational, so they are read a quarter period after the inputs change, still inside the same cycle. The blanking window is counted in cycles from the start write. The directed cases place completions two and three cycles after that write to hit both sides of its end.

// File: rtl/adc_flags_pkg.sv
// Shared register selects, status clear bit positions and decoded command type.
package adc_flags_pkg;

    localparam int ADDR_W = 3;
    localparam int STAT_W = 3;

    // Bit positions inside a status clear write
    localparam int CLR_SEQ_BIT = 0;
    localparam int CLR_TOV_BIT = 1;
    localparam int CLR_FOV_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CFG_A = 3'd0,
        SEL_CFG_B = 3'd1,
        SEL_CFG_C = 3'd2,
        SEL_GO    = 3'd3,
        SEL_STAT  = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic go;       // start register written
        logic abort;    // control register written
        logic clr_seq;  // write-one-to-clear of sequence flag
        logic clr_tov;  // write-one-to-clear of trigger overrun
        logic clr_fov;  // write-one-to-clear of result overrun
    } bus_cmd_t;

endpackage

// File: rtl/adc_bus_decode.sv
// Decodes register writes into start, abort and status-clear commands and
// turns a result read into a one-hot channel clear vector when clear-on-read
// is enabled. Assumes one bus access per cycle; purely combinational.
module adc_bus_decode
    import adc_flags_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int IDX_W = $clog2(N_CH)
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic              res_rd,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic              fast_clr_en,
    output bus_cmd_t          cmd,
    output logic [N_CH-1:0]   rd_clr
);

    // Map a write address onto exactly one command class
    always_comb begin
        cmd = '0;
        if (bus_wr) begin
            case (bus_addr)
                SEL_CFG_A, SEL_CFG_B, SEL_CFG_C: cmd.abort = 1'b1;
                SEL_GO:   cmd.go = 1'b1;
                SEL_STAT: begin
                    cmd.clr_seq = bus_wdata[CLR_SEQ_BIT];
                    cmd.clr_tov = bus_wdata[CLR_TOV_BIT];
                    cmd.clr_fov = bus_wdata[CLR_FOV_BIT];
                end
                default: cmd = '0;
            endcase
        end
    end

    // One clear line per channel, raised by a read of its result register
    for (genvar i = 0; i < N_CH; i++) begin : g_rdclr
        assign rd_clr[i] = res_rd & fast_clr_en & (res_idx == IDX_W'(i));
    end

endmodule

// File: rtl/adc_start_guard.sv
// Blanking window after a start write: completions from the conversion that
// was in flight are discarded during the write cycle and GUARD_CYC cycles
// after it. Assumes GUARD_CYC >= 0; a new start reloads the window.
module adc_start_guard #(
    parameter int GUARD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic blank
);

    localparam int CNT_W = $clog2(GUARD_CYC + 2);

    logic [CNT_W-1:0] cnt;

    // Count down the remaining blanked cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (go)         cnt <= CNT_W'(GUARD_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign blank = go | (cnt != '0);

    // Window never exceeds its configured length (R4)
    always_comb begin
        if (rst_n) a_cnt_range_r4: assert (int'(cnt) <= GUARD_CYC);
    end

    if (GUARD_CYC > 0) begin : g_win_chk
        p_window_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
            go |=> blank);
    end

endmodule

// File: rtl/adc_chan_flags.sv
// Per-channel conversion-complete flags. Each bit has its own set and clear
// so a read-clear of one channel never masks a set of another. Priority per
// bit: start clear, then accepted completion, then read clear.
module adc_chan_flags #(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            blank,
    input  logic [N_CH-1:0] done,
    input  logic [N_CH-1:0] rd_clr,
    output logic [N_CH-1:0] flags
);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // Update one channel flag from its own set and clear requests
        always_ff @(posedge clk) begin
            if (!rst_n)                   flags[i] <= 1'b0;
            else if (go)                  flags[i] <= 1'b0;
            else if (done[i] && !blank)   flags[i] <= 1'b1;
            else if (rd_clr[i])           flags[i] <= 1'b0;
        end

        p_set_not_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (done[i] && !blank && !go) |=> flags[i]);

        p_blank_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (blank && !flags[i]) |=> !flags[i]);

        p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr[i] && !done[i]) |=> !flags[i]);

        p_start_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            go |=> !flags[i]);
    end

    p_rdclr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clr));

endmodule

// File: rtl/adc_evt_flags.sv
// Sequence-complete, trigger-overrun and result-overrun flags plus the gated
// sequence interrupt flag. Detects the active trigger edge from a registered
// copy of the trigger level. Assumes trig_in is already synchronous.
module adc_evt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic abort,
    input  logic ext_start,
    input  logic clr_seq,
    input  logic clr_tov,
    input  logic clr_fov,
    input  logic blank,
    input  logic seq_done,
    input  logic trig_in,
    input  logic trig_pol,
    input  logic conv_busy,
    input  logic fifo_ovf,
    input  logic irq_en,
    output logic seq_flag,
    output logic trig_ovr,
    output logic fifo_ovr,
    output logic seq_irq
);

    logic trig_q;
    logic act_edge;
    logic seq_n;

    // Remember the previous trigger level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    assign act_edge = trig_pol ? (trig_in & ~trig_q) : (~trig_in & trig_q);

    // Next sequence flag: start clear first, then set, then write-one-clear
    always_comb begin
        if (go)                      seq_n = 1'b0;
        else if (seq_done && !blank) seq_n = 1'b1;
        else if (clr_seq)            seq_n = 1'b0;
        else                         seq_n = seq_flag;
    end

    // Register the sequence flag and its enabled interrupt copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_flag <= 1'b0;
            seq_irq  <= 1'b0;
        end else begin
            seq_flag <= seq_n;
            seq_irq  <= seq_n & irq_en;
        end
    end

    // Trigger overrun: abort clears, busy active edge sets, status write clears
    always_ff @(posedge clk) begin
        if (!rst_n)                      trig_ovr <= 1'b0;
        else if (abort)                  trig_ovr <= 1'b0;
        else if (act_edge && conv_busy)  trig_ovr <= 1'b1;
        else if (clr_tov)                trig_ovr <= 1'b0;
    end

    // Result overrun: any sequence start clears, overrun sets, status write clears
    always_ff @(posedge clk) begin
        if (!rst_n)                fifo_ovr <= 1'b0;
        else if (go || ext_start)  fifo_ovr <= 1'b0;
        else if (fifo_ovf)         fifo_ovr <= 1'b1;
        else if (clr_fov)          fifo_ovr <= 1'b0;
    end

    p_irq_needs_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        seq_irq |-> seq_flag);

    p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !trig_ovr);

    p_ovr_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_ovr && !(act_edge && conv_busy)) |=> !trig_ovr);

    p_start_clears_fifo_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (go || ext_start) |=> !fifo_ovr);

    p_start_clears_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!seq_flag && !seq_irq));

    p_set_beats_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !blank) |=> seq_flag);

endmodule

// File: rtl/adc_seq_flags.sv
// Top of the ADC sequence status flag logic. Wires the bus decoder, the
// post-start blanking window, the per-channel flags and the event flags.
// Assumes all inputs are synchronous to clk and event inputs are pulses.
module adc_seq_flags
    import adc_flags_pkg::*;
#(
    parameter int N_CH      = 8,
    parameter int GUARD_CYC = 2,
    localparam int IDX_W    = $clog2(N_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    input  logic              res_rd,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic              fast_clr_en,
    input  logic              seq_irq_en,
    input  logic              trig_pol,
    input  logic              trig_in,
    input  logic              conv_busy,
    input  logic [N_CH-1:0]   chan_done,
    input  logic              seq_done,
    input  logic              ext_start,
    input  logic              fifo_ovf,
    output logic [N_CH-1:0]   ch_flags,
    output logic              seq_flag,
    output logic              trig_ovr,
    output logic              fifo_ovr,
    output logic              seq_irq,
    output logic              seq_start,
    output logic              seq_abort
);

    bus_cmd_t        cmd;
    logic [N_CH-1:0] rd_clr;
    logic            blank;

    adc_bus_decode #(.N_CH(N_CH), .IDX_W(IDX_W)) u_dec (
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .res_rd      (res_rd),
        .res_idx     (res_idx),
        .fast_clr_en (fast_clr_en),
        .cmd         (cmd),
        .rd_clr      (rd_clr)
    );

    adc_start_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (cmd.go),
        .blank (blank)
    );

    adc_chan_flags #(.N_CH(N_CH)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (cmd.go),
        .blank  (blank),
        .done   (chan_done),
        .rd_clr (rd_clr),
        .flags  (ch_flags)
    );

    adc_evt_flags u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (cmd.go),
        .abort     (cmd.abort),
        .ext_start (ext_start),
        .clr_seq   (cmd.clr_seq),
        .clr_tov   (cmd.clr_tov),
        .clr_fov   (cmd.clr_fov),
        .blank     (blank),
        .seq_done  (seq_done),
        .trig_in   (trig_in),
        .trig_pol  (trig_pol),
        .conv_busy (conv_busy),
        .fifo_ovf  (fifo_ovf),
        .irq_en    (seq_irq_en),
        .seq_flag  (seq_flag),
        .trig_ovr  (trig_ovr),
        .fifo_ovr  (fifo_ovr),
        .seq_irq   (seq_irq)
    );

    assign seq_start = cmd.go;
    assign seq_abort = cmd.abort;

    // Decoded start and abort never appear without a bus write (R12)
    p_cmd_needs_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_start || seq_abort) |-> bus_wr);

endmodule

// File: tb/adc_seq_flags_test.sv
module adc_seq_flags_test;

    localparam int PER   = 10;
    localparam int N_CH  = 8;
    localparam int GUARD = 2;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_wr;
    logic [2:0] bus_addr;
    logic [2:0] bus_wdata;
    logic       res_rd;
    logic [2:0] res_idx;
    logic       fast_clr_en, seq_irq_en, trig_pol, trig_in, conv_busy;
    logic [7:0] chan_done;
    logic       seq_done, ext_start, fifo_ovf;
    logic [7:0] ch_flags;
    logic       seq_flag, trig_ovr, fifo_ovr, seq_irq, seq_start, seq_abort;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct packed {
        logic [7:0] ch;
        logic       seq, tov, fov, irq, prev;
        logic [7:0] g;
    } mstate_t;

    mstate_t m;

    always #(PER/2) clk = ~clk;

    adc_seq_flags #(.N_CH(N_CH), .GUARD_CYC(GUARD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .res_rd(res_rd), .res_idx(res_idx),
        .fast_clr_en(fast_clr_en), .seq_irq_en(seq_irq_en), .trig_pol(trig_pol),
        .trig_in(trig_in), .conv_busy(conv_busy), .chan_done(chan_done),
        .seq_done(seq_done), .ext_start(ext_start), .fifo_ovf(fifo_ovf),
        .ch_flags(ch_flags), .seq_flag(seq_flag), .trig_ovr(trig_ovr),
        .fifo_ovr(fifo_ovr), .seq_irq(seq_irq), .seq_start(seq_start),
        .seq_abort(seq_abort)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic exp_start();
        return bus_wr && (bus_addr == 3'd3);
    endfunction

    function automatic logic exp_abort();
        return bus_wr && (bus_addr <= 3'd2);
    endfunction

    // Expected next state from the requirements and the current inputs
    function automatic mstate_t model_step(input mstate_t s);
        mstate_t    n;
        logic       go, ab, guard, edge_a;
        logic [2:0] w1c;
        logic [7:0] setv, clrv;
        go     = exp_start();
        ab     = exp_abort();
        w1c    = (bus_wr && bus_addr == 3'd4) ? bus_wdata : 3'b000;
        guard  = go || (s.g != 0);
        setv   = guard ? 8'h00 : chan_done;
        clrv   = (fast_clr_en && res_rd) ? (8'h01 << res_idx) : 8'h00;
        edge_a = trig_pol ? (trig_in && !s.prev) : (!trig_in && s.prev);
        n      = s;
        n.ch   = go ? 8'h00 : ((s.ch & ~clrv) | setv);
        n.seq  = go ? 1'b0 : ((seq_done && !guard) || (s.seq && !w1c[0]));
        n.tov  = ab ? 1'b0 : ((edge_a && conv_busy) || (s.tov && !w1c[1]));
        n.fov  = (go || ext_start) ? 1'b0 : (fifo_ovf || (s.fov && !w1c[2]));
        n.irq  = seq_irq_en && n.seq;
        n.g    = go ? 8'(GUARD) : ((s.g != 0) ? s.g - 8'd1 : 8'd0);
        n.prev = trig_in;
        return n;
    endfunction

    // One cycle: check the decoded pulses, advance, check the flags
    task automatic tick(input string tag);
        mstate_t nx;
        #(PER/4);
        chk({tag, " R12 seq_start"}, seq_start, exp_start());
        chk({tag, " R12 seq_abort"}, seq_abort, exp_abort());
        nx = model_step(m);
        @(posedge clk);
        #(PER/4);
        m = nx;
        chk({tag, " ch_flags"}, ch_flags, m.ch);
        chk({tag, " seq_flag"}, seq_flag, m.seq);
        chk({tag, " trig_ovr"}, trig_ovr, m.tov);
        chk({tag, " fifo_ovr"}, fifo_ovr, m.fov);
        chk({tag, " seq_irq"},  seq_irq,  m.irq);
    endtask

    task automatic idle();
        bus_wr = 0; bus_addr = 0; bus_wdata = 0; res_rd = 0; res_idx = 0;
        chan_done = 0; seq_done = 0; ext_start = 0; fifo_ovf = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [2:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        fast_clr_en = 0; seq_irq_en = 1; trig_pol = 1; trig_in = 0; conv_busy = 0;
        m = '0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1 reset ch", ch_flags, 0);
        chk("R1 reset evt", {seq_flag, trig_ovr, fifo_ovr, seq_irq}, 0);

        @(negedge clk); idle(); chan_done = 8'h05; tick("R2 set");
        chk("R2 two flags", ch_flags, 8'h05);
        @(negedge clk); idle(); tick("R2 hold");
        chk("R2 held", ch_flags, 8'h05);
        @(negedge clk); idle(); fast_clr_en = 1; res_rd = 1; res_idx = 0; chan_done = 8'h02; tick("R6 clr x set y");
        chk("R6 y survives", ch_flags, 8'h06);
        @(negedge clk); idle(); fast_clr_en = 0; res_rd = 1; res_idx = 2; tick("R5 read no fast");
        chk("R5 read ignored", ch_flags, 8'h06);
        @(negedge clk); idle(); fast_clr_en = 1; res_rd = 1; res_idx = 2; chan_done = 8'h04; tick("R6 same bit");
        chk("R6 set wins", ch_flags, 8'h06);
        @(negedge clk); idle(); res_rd = 1; res_idx = 1; tick("R5 fast read");
        chk("R5 cleared", ch_flags, 8'h04);
        @(negedge clk); idle(); seq_done = 1; tick("R11 seq");
        chk("R11 irq on", {seq_flag, seq_irq}, 2'b11);
        @(negedge clk); idle(); wr(3'd4, 3'b000); tick("R7 zero bits");
        chk("R7 kept", seq_flag, 1);
        @(negedge clk); idle(); seq_irq_en = 0; tick("R11 gated");
        chk("R11 irq off", {seq_flag, seq_irq}, 2'b10);
        @(negedge clk); idle(); seq_irq_en = 1; wr(3'd3, 0); chan_done = 8'h80; seq_done = 1; tick("R3 start");
        chk("R3 all clear", {ch_flags, seq_flag, seq_irq}, 0);
        @(negedge clk); idle(); chan_done = 8'h10; seq_done = 1; tick("R4 blank1");
        chk("R4 blank1", {ch_flags, seq_flag}, 0);
        @(negedge clk); idle(); chan_done = 8'h20; tick("R4 blank2");
        chk("R4 blank2", ch_flags, 0);
        @(negedge clk); idle(); chan_done = 8'h40; seq_done = 1; tick("R4 reopen");
        chk("R4 reopen", {ch_flags, seq_flag}, {8'h40, 1'b1});
        @(negedge clk); idle(); wr(3'd4, 3'b001); seq_done = 1; tick("R7 set wins");
        chk("R7 set wins", seq_flag, 1);
        @(negedge clk); idle(); wr(3'd4, 3'b001); tick("R7 clear seq");
        chk("R7 clear seq", seq_flag, 0);
        @(negedge clk); idle(); conv_busy = 1; trig_in = 1; tick("R9 rising");
        chk("R9 rising", trig_ovr, 1);
        @(negedge clk); idle(); wr(3'd4, 3'b010); tick("R7 clear tov");
        chk("R7 clear tov", trig_ovr, 0);
        @(negedge clk); idle(); trig_in = 0; tick("R9 inactive");
        chk("R9 inactive", trig_ovr, 0);
        @(negedge clk); idle(); conv_busy = 0; trig_in = 1; tick("R9 idle");
        chk("R9 idle", trig_ovr, 0);
        @(negedge clk); idle(); conv_busy = 1; trig_pol = 0; trig_in = 0; tick("R9 falling");
        chk("R9 falling", trig_ovr, 1);
        @(negedge clk); idle(); trig_in = 1; tick("R9 prep");
        @(negedge clk); idle(); wr(3'd2, 3'b000); trig_in = 0; tick("R8 abort");
        chk("R8 abort", {trig_ovr, ch_flags}, {1'b0, 8'h40});
        @(negedge clk); idle(); fifo_ovf = 1; tick("R10 set");
        chk("R10 set", fifo_ovr, 1);
        @(negedge clk); idle(); fifo_ovf = 1; ext_start = 1; tick("R10 ext");
        chk("R10 ext clear", fifo_ovr, 0);
        @(negedge clk); idle(); fifo_ovf = 1; tick("R10 set2");
        @(negedge clk); idle(); wr(3'd4, 3'b100); tick("R7 clear fov");
        chk("R7 clear fov", fifo_ovr, 0);
        @(negedge clk); idle(); fifo_ovf = 1; wr(3'd3, 0); tick("R10 go");
        chk("R10 go clears", fifo_ovr, 0);

        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            idle();
            if ($urandom % 8 == 0) wr(3'($urandom % 6), 3'($urandom));
            res_rd    = ($urandom % 3 == 0);
            res_idx   = 3'($urandom);
            chan_done = 8'($urandom) & 8'($urandom) & 8'($urandom);
            seq_done  = ($urandom % 10 == 0);
            ext_start = ($urandom % 20 == 0);
            fifo_ovf  = ($urandom % 10 == 0);
            if ($urandom % 4 == 0)  trig_in = ~trig_in;
            if ($urandom % 5 == 0)  conv_busy = ~conv_busy;
            if ($urandom % 50 == 0) trig_pol = ~trig_pol;
            if ($urandom % 30 == 0) fast_clr_en = ~fast_clr_en;
            if ($urandom % 30 == 0) seq_irq_en = ~seq_irq_en;
            tick("R2 R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule